// File: doc/BRIEF.md
# Register-List Block Transfer Sequencer

This block carries out the multi-register memory transfers of a 16-bit compressed instruction set: load-multiple and store-multiple through a named base register, and push and pop through the stack pointer r13. A single start pulse supplies the operation, an 8-bit mask over the low registers r0..r7, an extra-register flag and a base register index. The sequencer then walks the selected registers, emits one word-wide memory request per register, drives the register file's read and write ports, and finally writes the updated address back to the base register.

Registers always move in ascending number order, so the lowest selected register meets the lowest address. The extra register goes last: r14 on push, r15 on pop. A loaded r15 does not go to the register file; it leaves as a fetch-redirect target with bit 0 cleared. Memory is a plain request/ready handshake, and each beat holds until ready is seen.

Top module: `blk_xfer_seq`

## Requirements
- R1: While and after reset, before any start, busy_o, done_o, mem_req_o, rf_we_o and redirect_o are low.
- R2: The operation code is 0 = load-multiple, 1 = store-multiple, 2 = push, 3 = pop. Beats visit selected registers in ascending order at ascending addresses, and the extra register (r14 for push, r15 for pop) takes the final, highest address.
- R3: Load/store-multiple start at the base register value and step the address by 4 each beat. The base register receives base + 4 * count in the done cycle.
- R4: Push always uses r13. It stores from r13 - 4 * count upward and writes r13 - 4 * count back to r13. With the extra flag set it stores r14 last.
- R5: Pop always uses r13. It loads upward from r13 and writes r13 + 4 * count back to r13. With the extra flag set the last word is presented on redirect_pc_o with bit 0 cleared, and redirect_o pulses in the done cycle.
- R6: The count is the number of ones in the mask plus the extra flag. Exactly that many memory beats occur.
- R7: A beat holds mem_req_o, mem_addr_o and mem_we_o steady until mem_ready_i is high, and it completes in that cycle.
- R8: Store beats drive mem_we_o high with the selected register's value on mem_wdata_o. Load beats drive mem_we_o low and write mem_rdata_i into the register file in the ready cycle.
- R9: An empty mask with the extra flag clear makes no memory request and no register write. done_o is high in the cycle after start.
- R10: busy_o is high from the cycle after an accepted start through the done cycle. done_o lasts one cycle. A start pulse while busy is ignored.
- R11: The extra flag has no effect on load/store-multiple.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled while idle |
| op_i | input | 2 | Operation code |
| list_i | input | 8 | Low-register select mask |
| extra_i | input | 1 | Extra register (r14/r15) flag |
| base_i | input | 4 | Base register index for load/store-multiple |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Final cycle of an operation |
| rf_raddr_o | output | 4 | Register file data read index |
| rf_rdata_i | input | 32 | Register file data read value |
| rf_baddr_o | output | 4 | Register file base read index |
| rf_bdata_i | input | 32 | Register file base read value |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | 4 | Register file write index |
| rf_wdata_o | output | 32 | Register file write value |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (store) |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory store data |
| mem_rdata_i | input | 32 | Memory load data |
| mem_ready_i | input | 1 | Memory beat completes |
| redirect_o | output | 1 | Fetch redirect after a pop that loads r15 |
| redirect_pc_o | output | 32 | Fetch redirect target |

## Verification
The stack-pointer write-back and the fetch redirect both fall in the done cycle of a pop with the extra flag set. The vectors that provoke this use pops with and without low registers and with memory wait states, and they judge that r13 ends at the incremented value while the redirect target equals the last word read with bit 0 cleared. A second collision, a start pulse arriving during an active transfer, is provoked by a directed test that pulses a pop request mid-store. It is judged by the beat count, the addresses and the final base value, all of which must match the first operation alone.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  typedef enum logic [1:0] {
    OP_LDM  = 2'd0,
    OP_STM  = 2'd1,
    OP_PUSH = 2'd2,
    OP_POP  = 2'd3
  } xfer_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_FIN
  } xfer_st_e;
endpackage

// File: rtl/xfer_popcnt.sv
module xfer_popcnt #(
  parameter int N = 8,
  parameter int W = $clog2(N + 1)
) (
  input  logic [N-1:0] bits_i,
  output logic [W-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < N; i++) cnt_o = cnt_o + W'(bits_i[i]);
  end
endmodule

// File: rtl/xfer_lsb_pick.sv
module xfer_lsb_pick #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  mask_i,
  output logic [N-1:0]  oh_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  for (genvar i = 0; i < N; i++) begin : g_oh
    if (i == 0) begin : g_first
      assign oh_o[i] = mask_i[i];
    end else begin : g_rest
      assign oh_o[i] = mask_i[i] & ~|mask_i[i-1:0];
    end
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) if (oh_o[i]) idx_o = IW'(i);
  end

  assign any_o = |mask_i;
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import xfer_pkg::*;
#(
  parameter int LIST_W = 8,
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int RI_W   = 4,
  parameter int BYTES  = 4,
  parameter int SP_IDX = 13,
  parameter int LR_IDX = 14,
  parameter int PC_IDX = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [LIST_W-1:0] list_i,
  input  logic              extra_i,
  input  logic [RI_W-1:0]   base_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [RI_W-1:0]   rf_raddr_o,
  input  logic [DW-1:0]     rf_rdata_i,
  output logic [RI_W-1:0]   rf_baddr_o,
  input  logic [DW-1:0]     rf_bdata_i,
  output logic              rf_we_o,
  output logic [RI_W-1:0]   rf_waddr_o,
  output logic [DW-1:0]     rf_wdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic [DW-1:0]     mem_rdata_i,
  input  logic              mem_ready_i,
  output logic              redirect_o,
  output logic [AW-1:0]     redirect_pc_o
);
  localparam int CNT_W = $clog2(LIST_W + 2);
  localparam int LI_W  = $clog2(LIST_W);
  localparam logic [RI_W-1:0] SP_R = RI_W'(SP_IDX);
  localparam logic [RI_W-1:0] LR_R = RI_W'(LR_IDX);
  localparam logic [RI_W-1:0] PC_R = RI_W'(PC_IDX);

  xfer_st_e          state_q;
  xfer_op_e          op_q, op_in;
  logic [LIST_W-1:0] mask_q;
  logic              ext_q;
  logic [RI_W-1:0]   base_q;
  logic [AW-1:0]     addr_q, wb_q, pc_q;
  logic              wb_en_q, redir_q;

  // start-side decode
  logic              stack_in, ext_in;
  logic [CNT_W-1:0]  pop_cnt, cnt_in;
  logic [AW-1:0]     span, lo_addr, wb_in;

  assign op_in    = xfer_op_e'(op_i);
  assign stack_in = op_i[1];
  assign ext_in   = extra_i & stack_in;

  xfer_popcnt #(.N(LIST_W), .W(CNT_W)) i_popcnt (
    .bits_i (list_i),
    .cnt_o  (pop_cnt)
  );

  assign cnt_in  = pop_cnt + CNT_W'(ext_in);
  assign span    = AW'(cnt_in) * AW'(BYTES);
  assign lo_addr = (op_in == OP_PUSH) ? rf_bdata_i - span : rf_bdata_i;
  assign wb_in   = (op_in == OP_PUSH) ? lo_addr : rf_bdata_i + span;

  // beat-side selection
  logic [LIST_W-1:0] cur_oh;
  logic [LI_W-1:0]   cur_lo;
  logic              cur_any, cur_last, is_load, beat;
  logic [RI_W-1:0]   cur_idx;

  xfer_lsb_pick #(.N(LIST_W), .IW(LI_W)) i_pick (
    .mask_i (mask_q),
    .oh_o   (cur_oh),
    .idx_o  (cur_lo),
    .any_o  (cur_any)
  );

  assign cur_idx  = cur_any ? RI_W'(cur_lo) : ((op_q == OP_PUSH) ? LR_R : PC_R);
  assign cur_last = cur_any ? (((mask_q & ~cur_oh) == '0) && !ext_q) : 1'b1;
  assign is_load  = (op_q == OP_LDM) || (op_q == OP_POP);
  assign beat     = (state_q == ST_XFER) && mem_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_LDM;
      mask_q  <= '0;
      ext_q   <= 1'b0;
      base_q  <= '0;
      addr_q  <= '0;
      wb_q    <= '0;
      pc_q    <= '0;
      wb_en_q <= 1'b0;
      redir_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            op_q    <= op_in;
            mask_q  <= list_i;
            ext_q   <= ext_in;
            base_q  <= stack_in ? SP_R : base_i;
            addr_q  <= lo_addr;
            wb_q    <= wb_in;
            wb_en_q <= (cnt_in != '0);
            redir_q <= 1'b0;
            state_q <= (cnt_in == '0) ? ST_FIN : ST_XFER;
          end
        end
        ST_XFER: begin
          if (mem_ready_i) begin
            if (cur_any) mask_q <= mask_q & ~cur_oh;
            else         ext_q  <= 1'b0;
            addr_q <= addr_q + AW'(BYTES);
            if (is_load && cur_idx == PC_R) begin
              pc_q    <= mem_rdata_i & ~AW'(1);
              redir_q <= 1'b1;
            end
            if (cur_last) state_q <= ST_FIN;
          end
        end
        default: begin
          state_q <= ST_IDLE;
          redir_q <= 1'b0;
        end
      endcase
    end
  end

  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = (state_q == ST_FIN);
  assign rf_baddr_o    = (state_q == ST_IDLE) ? (stack_in ? SP_R : base_i) : base_q;
  assign rf_raddr_o    = cur_idx;
  assign mem_req_o     = (state_q == ST_XFER);
  assign mem_we_o      = mem_req_o && !is_load;
  assign mem_addr_o    = addr_q;
  assign mem_wdata_o   = rf_rdata_i;
  assign redirect_o    = done_o && redir_q;
  assign redirect_pc_o = pc_q;

  // base write-back owns the port in the done cycle; load beats use it otherwise
  always_comb begin
    rf_we_o    = 1'b0;
    rf_waddr_o = cur_idx;
    rf_wdata_o = mem_rdata_i;
    if (done_o && wb_en_q) begin
      rf_we_o    = 1'b1;
      rf_waddr_o = base_q;
      rf_wdata_o = wb_q;
    end else if (beat && is_load && cur_idx != PC_R) begin
      rf_we_o = 1'b1;
    end
  end
endmodule

// File: rtl/xfer_seq_chk.sv
module xfer_seq_chk #(
  parameter int AW    = 32,
  parameter int BYTES = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_ready_i,
  input logic          rf_we_o,
  input logic          redirect_o,
  input logic [AW-1:0] redirect_pc_o
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)); // R7

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ready_i |=> !mem_req_o || (mem_addr_o == $past(mem_addr_o) + AW'(BYTES))); // R3

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && !rf_we_o && !done_o); // R10

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && start_i |=> busy_o); // R10

  AST_REDIR_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> done_o && !redirect_pc_o[0]); // R5
endmodule

bind blk_xfer_seq xfer_seq_chk #(.AW(AW), .BYTES(BYTES)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_i       (start_i),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .mem_req_o     (mem_req_o),
  .mem_we_o      (mem_we_o),
  .mem_addr_o    (mem_addr_o),
  .mem_ready_i   (mem_ready_i),
  .rf_we_o       (rf_we_o),
  .redirect_o    (redirect_o),
  .redirect_pc_o (redirect_pc_o)
);

// File: tb/test_blk_xfer_seq.sv
module test_blk_xfer_seq;
  localparam int CLK_P = 10;
  localparam logic [1:0] LDM = 2'd0, STM = 2'd1, PUSH = 2'd2, POP = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  list;
    logic        ext;
    logic [3:0]  base;
    logic [31:0] bval;
    logic [1:0]  wt;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{STM,  8'h23, 1'b0, 4'd9,  32'h0000_0100, 2'd0},
    '{LDM,  8'h81, 1'b0, 4'd2,  32'h0000_0120, 2'd1},
    '{PUSH, 8'h1F, 1'b1, 4'd5,  32'h0000_0180, 2'd0},
    '{POP,  8'h44, 1'b1, 4'd13, 32'h0000_0160, 2'd2},
    '{STM,  8'hFF, 1'b0, 4'd3,  32'h0000_0100, 2'd1},
    '{LDM,  8'h04, 1'b1, 4'd7,  32'h0000_01C0, 2'd0},
    '{POP,  8'h00, 1'b1, 4'd13, 32'h0000_01A0, 2'd1},
    '{PUSH, 8'h80, 1'b0, 4'd13, 32'h0000_01F0, 2'd3}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, ext = 1'b0;
  logic [1:0] op = '0;
  logic [7:0] list = '0;
  logic [3:0] base = '0;
  logic busy, done, rf_we, mem_req, mem_we, mem_rdy, redir;
  logic [3:0] rf_raddr, rf_baddr, rf_waddr;
  logic [31:0] rf_rdata, rf_bdata, rf_wdata, mem_addr, mem_wdata, mem_rdata, redir_pc;

  logic [31:0] rf_m [16];
  logic [31:0] mem_m [64];
  logic [31:0] rf_snap [16];
  logic [31:0] mem_snap [64];
  logic [1:0]  wcnt, wait_cfg = '0;
  logic        bset_en = 1'b0;
  logic [3:0]  bset_idx = '0;
  logic [31:0] bset_val = '0;
  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  blk_xfer_seq i_blk_xfer_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .list_i(list),
    .extra_i(ext), .base_i(base), .busy_o(busy), .done_o(done),
    .rf_raddr_o(rf_raddr), .rf_rdata_i(rf_rdata), .rf_baddr_o(rf_baddr),
    .rf_bdata_i(rf_bdata), .rf_we_o(rf_we), .rf_waddr_o(rf_waddr),
    .rf_wdata_o(rf_wdata), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .mem_ready_i(mem_rdy), .redirect_o(redir), .redirect_pc_o(redir_pc)
  );

  // register file and memory environment
  assign rf_rdata  = rf_m[rf_raddr];
  assign rf_bdata  = rf_m[rf_baddr];
  assign mem_rdata = mem_m[mem_addr[7:2]];
  assign mem_rdy   = mem_req && (wcnt == wait_cfg);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) rf_m[i] <= 32'hA000_0000 + 32'(i) * 32'h111;
      for (int j = 0; j < 64; j++) mem_m[j] <= 32'hC000_0001 + 32'(j) * 32'd8;
      wcnt <= '0;
    end else begin
      if (bset_en) rf_m[bset_idx] <= bset_val;
      if (rf_we) rf_m[rf_waddr] <= rf_wdata;
      if (mem_req && !mem_rdy) wcnt <= wcnt + 2'd1;
      else wcnt <= '0;
      if (mem_req && mem_rdy && mem_we) mem_m[mem_addr[7:2]] <= mem_wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic set_reg(input logic [3:0] idx, input logic [31:0] val);
    @(negedge clk);
    bset_en = 1'b1; bset_idx = idx; bset_val = val;
    @(negedge clk);
    bset_en = 1'b0;
  endtask

  task automatic run(input vec_t v, input bit inject);
    int regs[10];
    int n = 0, k = 0, cyc = 0;
    bit seen_done = 1'b0, seen_redir = 1'b0, stack, is_ld;
    logic [31:0] rpc = '0, lo, wb, a;
    logic [3:0] breg;
    stack = v.op[1];
    is_ld = (v.op == LDM) || (v.op == POP);
    breg  = stack ? 4'd13 : v.base;
    for (int i = 0; i < 8; i++) if (v.list[i]) begin regs[n] = i; n++; end
    if (stack && v.ext) begin regs[n] = (v.op == PUSH) ? 14 : 15; n++; end
    lo = (v.op == PUSH) ? v.bval - 32'(4 * n) : v.bval;
    wb = (v.op == PUSH) ? lo : v.bval + 32'(4 * n);
    set_reg(breg, v.bval);
    for (int i = 0; i < 16; i++) rf_snap[i] = rf_m[i];
    for (int j = 0; j < 64; j++) mem_snap[j] = mem_m[j];
    wait_cfg = v.wt;
    start = 1'b1; op = v.op; list = v.list; ext = v.ext; base = v.base;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10", "busy after start", 32'(busy), 32'd1);
    while (!seen_done && cyc < 300) begin
      if (inject && cyc == 0) begin
        start = 1'b1; op = POP; list = 8'hFF; ext = 1'b1;
      end else if (inject && cyc == 1) begin
        start = 1'b0;
      end
      if (mem_req && mem_rdy) begin
        if (k < n) begin
          a = lo + 32'(4 * k);
          chk(mem_addr == a, "R2", "beat address", mem_addr, a);
          chk(mem_we == !is_ld, "R8", "beat direction", 32'(mem_we), 32'(!is_ld));
          if (!is_ld)
            chk(mem_wdata == rf_snap[regs[k]], "R8", "store data", mem_wdata, rf_snap[regs[k]]);
        end
        k++;
      end
      if (done) begin
        seen_done = 1'b1;
        seen_redir = redir;
        rpc = redir_pc;
      end else begin
        @(negedge clk);
        cyc++;
      end
    end
    chk(seen_done, "R10", "done reached", 32'(seen_done), 32'd1);
    chk(k == n, "R6", "beat count", 32'(k), 32'(n));
    if (n == 0) begin
      chk(cyc == 0, "R9", "empty list done delay", 32'(cyc), 32'd0);
      wb = v.bval;
    end
    chk(seen_redir == (v.op == POP && v.ext), "R5", "redirect pulse",
        32'(seen_redir), 32'(v.op == POP && v.ext));
    if (v.op == POP && v.ext) begin
      a = mem_snap[6'((lo + 32'(4 * (n - 1))) >> 2)] & ~32'd1;
      chk(rpc == a, "R5", "redirect target", rpc, a);
    end
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R10", "idle after done", {30'd0, busy, done}, 32'd0);
    chk(rf_m[breg] == wb, stack ? (v.op == PUSH ? "R4" : "R5") : "R3", "base write-back",
        rf_m[breg], wb);
    for (int q = 0; q < n; q++) begin
      a = lo + 32'(4 * q);
      if (!is_ld)
        chk(mem_m[a[7:2]] == rf_snap[regs[q]], v.op == PUSH ? "R4" : "R3", "stored word",
            mem_m[a[7:2]], rf_snap[regs[q]]);
      else if (regs[q] != 15 && regs[q] != int'(breg))
        chk(rf_m[regs[q]] == mem_snap[a[7:2]], v.op == POP ? "R5" : "R3", "loaded word",
            rf_m[regs[q]], mem_snap[a[7:2]]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R10", "watchdog expired", 32'd0, 32'd1);
    summary();
    $finish;
  end

  initial begin
    vec_t d;
    repeat (3) @(negedge clk);
    chk({busy, done, mem_req, rf_we, redir} == 5'b0, "R1", "outputs in reset",
        32'({busy, done, mem_req, rf_we, redir}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, mem_req, rf_we, redir} == 5'b0, "R1", "outputs after reset",
        32'({busy, done, mem_req, rf_we, redir}), 32'd0);

    // R2 R3 R4 R5 R6 R7 R8 R11 via the vector table
    for (int t = 0; t < NV; t++) run(VECS[t], 1'b0);

    // R9: empty mask, extra clear, on both a named base and the stack
    d = '{LDM, 8'h00, 1'b0, 4'd4, 32'h1234_5678, 2'd0};
    run(d, 1'b0);
    d = '{POP, 8'h00, 1'b0, 4'd13, 32'h0000_01B0, 2'd1};
    run(d, 1'b0);

    // R10: start pulse during a store is ignored
    d = '{STM, 8'h0E, 1'b0, 4'd6, 32'h0000_01D0, 2'd1};
    run(d, 1'b1);

    // R11: extra flag on store-multiple adds no beat
    d = '{STM, 8'h01, 1'b1, 4'd1, 32'h0000_0140, 2'd2};
    run(d, 1'b0);

    summary();
    $finish;
  end
endmodule